// File: doc/BRIEF.md
# Seconds Counter with Match Alarms and Wake Output

This block is a memory-mapped real-time-clock core. A free-running seconds count advances on every cycle in which a one-second tick enable is high. Beside it sits a second count that runs the other way. When software loads both with a value and its complement, the second count stays the bitwise inverse of the first. Two compare registers watch the seconds count. When an enabled compare equals the count, it sets a sticky status flag. The enabled flags drive a level interrupt. A wake output can be routed from either flag, or forced high from the control register.

Software reaches the block through a plain single-cycle register bus. A write takes effect on the clock edge that samples it. Read data is registered and appears after one edge. The window also holds a key register that keeps whatever word is written to it, so firmware can tell a configured clock from a fresh one. It also holds a 32-word scratch memory written in a form that maps onto block RAM. To set the time, firmware stops counting, loads the seconds value and its complement, then restarts counting.

Top module: `rtc_match_top`

## Requirements
- R1: After reset the seconds count reads 0, the reverse count reads 0xFFFFFFFF, and control, status, both compare registers and the key read 0. The interrupt and wake outputs are low.
- R2: Word offsets are 0x00 seconds count, 0x04 reverse count, 0x08 compare A, 0x0C compare B, 0x10 control, 0x14 status and 0x18 key. Read data appears one edge after the read. An offset whose two low bits are not zero, or that is not mapped, reads 0 and ignores writes.
- R3: On an edge with the tick high and counting allowed, the seconds count rises by one and the reverse count falls by one, both modulo 2^32. A bus write to either count wins over the tick.
- R4: While control bit 4 (clear-hold) is set, the counts stay at 0 and 0xFFFFFFFF and writes to them are ignored. The compare registers, the key and the scratch memory are not changed.
- R5: While control bit 6 (stop) is set, ticks do not change the counts, and loads through the bus still apply.
- R6: Status bit 0 (or bit 1) is set on the edge after compare A (or B) equals the seconds count while control bit 0 (or bit 1) is set. With the enable clear, no flag is set.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it. If the match still holds, the set wins over the clear.
- R8: The interrupt output goes high one edge after status bit 0 is set with control bit 0, or status bit 1 with control bit 1. It is low when every set flag has its enable clear.
- R9: The wake output is registered. It is high when control bit 7 is set, or when status bit 0 is set with control bit 2, or when status bit 1 is set with control bit 3.
- R10: Status bit 2 is set on the edge where the wake output rises, and a level that stays high does not set it again.
- R11: The key register at 0x18 holds and returns any 32-bit value.
- R12: The scratch memory holds 32 words. Word n is at 0x80 + 4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second count enable |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | AW (8) | Byte offset |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid one edge after the read |
| irq_o | output | 1 | Level interrupt from enabled match flags |
| wake_o | output | 1 | Wake request |

## Verification
Bus writes and counts settle on the edge that samples them. Read data follows one edge after the read strobe. A match flag follows one edge after the equality. The interrupt and the wake output follow the flag by one more edge, and the wake status bit rises in the same edge as the wake output. The bench drives inputs on falling edges and reads on falling edges. After any stimulus that affects flags, it idles three cycles before reading status or sampling the outputs, so every result is settled. Expected counts come from a tracked seconds value computed in the bench, and the reverse count is checked against its complement.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // register word offsets (byte addresses)
  localparam int OFS_UP   = 'h00;
  localparam int OFS_DN   = 'h04;
  localparam int OFS_CMPA = 'h08;
  localparam int OFS_CMPB = 'h0C;
  localparam int OFS_CTRL = 'h10;
  localparam int OFS_STS  = 'h14;
  localparam int OFS_KEY  = 'h18;
  // control bit positions
  localparam int C_ENA   = 0;
  localparam int C_ENB   = 1;
  localparam int C_WKA   = 2;
  localparam int C_WKB   = 3;
  localparam int C_HOLD  = 4;
  localparam int C_STOP  = 6;
  localparam int C_FORCE = 7;
  localparam logic [7:0] CTRL_MASK = 8'hDF;
  // status bit positions
  localparam int S_A    = 0;
  localparam int S_B    = 1;
  localparam int S_WAKE = 2;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hold,
  input  logic          stop,
  input  logic          ld_up,
  input  logic          ld_dn,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] up,
  output logic [CW-1:0] dn
);
  logic adv;
  assign adv = tick && !stop;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      up <= '0;
      dn <= '1;
    end else begin
      if (ld_up)    up <= wdata;
      else if (adv) up <= up + CW'(1);
      if (ld_dn)    dn <= wdata;
      else if (adv) dn <= dn - CW'(1);
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && !hold && !ld_up && !ld_dn) |=>
      (up == $past(up) + CW'(1)) && (dn == $past(dn) - CW'(1)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (up == '0) && (dn == '1));
  // R5
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !hold && !ld_up && !ld_dn) |=> $stable(up) && $stable(dn));
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] up,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          wk_a,
  input  logic          wk_b,
  input  logic          force_hi,
  input  logic [2:0]    clr,
  output logic [2:0]    sts,
  output logic          irq,
  output logic          wake
);
  import rtc_pkg::*;
  logic hit_a, hit_b, wake_n;
  logic [2:0] sts_n;

  always_comb begin
    hit_a = en_a && (up == cmp_a);
    hit_b = en_b && (up == cmp_b);
    wake_n = force_hi || (sts[S_A] && wk_a) || (sts[S_B] && wk_b);
    sts_n[S_A]    = (sts[S_A] && !clr[S_A]) || hit_a;
    sts_n[S_B]    = (sts[S_B] && !clr[S_B]) || hit_b;
    sts_n[S_WAKE] = (sts[S_WAKE] && !clr[S_WAKE]) || (wake_n && !wake);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts  <= '0;
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      sts  <= sts_n;
      irq  <= (sts[S_A] && en_a) || (sts[S_B] && en_b);
      wake <= wake_n;
    end
  end

  // R6
  match_a_chk: assert property (@(posedge clk) disable iff (rst)
    (en_a && up == cmp_a) |=> sts[S_A]);
  // R6
  match_b_chk: assert property (@(posedge clk) disable iff (rst)
    (en_b && up == cmp_b) |=> sts[S_B]);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sts[S_A] && !clr[S_A]) |=> sts[S_A]);
  // R8
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((sts[S_A] && en_a) || (sts[S_B] && en_b)) |=> irq);
  // R9
  force_chk: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> wake);
  // R10
  wake_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> sts[S_WAKE]);
endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch #(
  parameter int DW    = 32,
  parameter int WORDS = 32,
  localparam int IAW  = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic           re,
  input  logic [IAW-1:0] idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  q
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/rtc_match_top.sv
module rtc_match_top #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int SCR_WORDS = 32,
  parameter int SCR_BASE  = 'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wake_o
);
  import rtc_pkg::*;
  localparam int SCR_AW = $clog2(SCR_WORDS);
  localparam int SCR_END = SCR_BASE + 4 * SCR_WORDS;

  logic [DW-1:0] up_q, dn_q, cmpa_q, cmpb_q, key_q, rd_mux, reg_rd_q, ram_q;
  logic [7:0]    ctrl_q;
  logic [2:0]    sts, clr;
  logic          aligned, scr_hit, scr_sel_q;
  logic [SCR_AW-1:0] scr_idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign scr_hit = aligned && (int'(addr_i) >= SCR_BASE) && (int'(addr_i) < SCR_END);
  assign scr_idx = SCR_AW'((int'(addr_i) - SCR_BASE) >> 2);

  function automatic logic wsel(input int ofs);
    return wr_en_i && aligned && (addr_i == AW'(ofs));
  endfunction

  assign clr = wsel(OFS_STS) ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpa_q <= '0;
      cmpb_q <= '0;
      key_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wsel(OFS_CMPA)) cmpa_q <= wdata_i;
      if (wsel(OFS_CMPB)) cmpb_q <= wdata_i;
      if (wsel(OFS_KEY))  key_q  <= wdata_i;
      if (wsel(OFS_CTRL)) ctrl_q <= wdata_i[7:0] & CTRL_MASK;
    end
  end

  rtc_counter #(.CW(DW)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick_i),
    .hold(ctrl_q[C_HOLD]), .stop(ctrl_q[C_STOP]),
    .ld_up(wsel(OFS_UP)), .ld_dn(wsel(OFS_DN)),
    .wdata(wdata_i), .up(up_q), .dn(dn_q)
  );

  rtc_flags #(.CW(DW)) i_flags (
    .clk(clk), .rst(rst), .up(up_q), .cmp_a(cmpa_q), .cmp_b(cmpb_q),
    .en_a(ctrl_q[C_ENA]), .en_b(ctrl_q[C_ENB]),
    .wk_a(ctrl_q[C_WKA]), .wk_b(ctrl_q[C_WKB]),
    .force_hi(ctrl_q[C_FORCE]), .clr(clr),
    .sts(sts), .irq(irq_o), .wake(wake_o)
  );

  rtc_scratch #(.DW(DW), .WORDS(SCR_WORDS)) i_scr (
    .clk(clk), .we(wr_en_i && scr_hit), .re(rd_en_i && scr_hit),
    .idx(scr_idx), .wdata(wdata_i), .q(ram_q)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (addr_i)
        AW'(OFS_UP):   rd_mux = up_q;
        AW'(OFS_DN):   rd_mux = dn_q;
        AW'(OFS_CMPA): rd_mux = cmpa_q;
        AW'(OFS_CMPB): rd_mux = cmpb_q;
        AW'(OFS_CTRL): rd_mux = {{(DW-8){1'b0}}, ctrl_q};
        AW'(OFS_STS):  rd_mux = {{(DW-3){1'b0}}, sts};
        AW'(OFS_KEY):  rd_mux = key_q;
        default:       rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      scr_sel_q <= 1'b0;
    end else if (rd_en_i) begin
      reg_rd_q  <= rd_mux;
      scr_sel_q <= scr_hit;
    end
  end

  assign rdata_o = scr_sel_q ? ram_q : reg_rd_q;

  // R4
  hold_keeps_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_HOLD] && !wsel(OFS_CMPA)) |=> $stable(cmpa_q));
  // R2
  misaligned_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !aligned) |=> (rdata_o == '0));
endmodule

// File: tb/test_rtc_match_top.sv
module test_rtc_match_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, wake_o;
  int          errors = 0, checks = 0;
  logic [31:0] eu;

  always #4 clk = ~clk;

  rtc_match_top i_rtc_match_top (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  function automatic logic [31:0] exp_down(input logic [31:0] u);
    return ~u;
  endfunction
  function automatic logic [31:0] exp_count(input logic [31:0] s, input int k);
    return s + 32'(k);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic load_time(input logic [31:0] s, input logic [31:0] ctrl_after);
    wr(8'h10, 32'h40);
    wr(8'h00, s);
    wr(8'h04, 32'hFFFF_FFFF - s);
    wr(8'h10, ctrl_after);
    eu = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, s, wv [32];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(8'h00, v); check("R1 up", v, 32'h0);
    rd(8'h04, v); check("R1 down", v, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R1 ctrl", v, 32'h0);
    rd(8'h14, v); check("R1 status", v, 32'h0);
    rd(8'h18, v); check("R1 key", v, 32'h0);
    rd(8'h08, v); check("R1 cmpA", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 wake", {31'b0, wake_o}, 32'h0);

    // R3/R5 random loads and counting
    for (int it = 0; it < 12; it++) begin
      int k;
      s = $urandom();
      k = 1 + int'($urandom_range(15));
      load_time(s, 32'h40);
      ticks(3);
      rd(8'h00, v); check("R5 stopped up", v, s);
      wr(8'h10, 32'h0);
      ticks(k);
      rd(8'h00, v); check("R3 up", v, exp_count(s, k));
      rd(8'h04, v); check("R3 down", v, exp_down(exp_count(s, k)));
    end
    // R3 wrap
    load_time(32'hFFFF_FFFF, 32'h0);
    ticks(1);
    rd(8'h00, v); check("R3 wrap up", v, 32'h0);
    rd(8'h04, v); check("R3 wrap down", v, 32'hFFFF_FFFF);
    eu = 32'h0;

    // R11 key
    s = $urandom();
    wr(8'h18, s); rd(8'h18, v); check("R11 key random", v, s);
    wr(8'h18, 32'hB5C1_3F27); rd(8'h18, v); check("R11 key marker", v, 32'hB5C1_3F27);

    // R12 scratch
    for (int n = 0; n < 32; n++) begin
      wv[n] = $urandom();
      wr(8'(8'h80 + 4 * n), wv[n]);
    end
    for (int n = 0; n < 32; n++) begin
      rd(8'(8'h80 + 4 * n), v); check("R12 scratch", v, wv[n]);
    end
    // R2 unmapped and misaligned
    wr(8'h20, 32'h1234_5678); rd(8'h20, v); check("R2 unmapped", v, 32'h0);
    wr(8'h81, 32'hDEAD_BEEF); rd(8'h80, v); check("R2 misaligned write", v, wv[0]);
    rd(8'h01, v); check("R2 misaligned read", v, 32'h0);

    // R6 disabled compare sets nothing
    load_time(32'h0000_1000, 32'h0);
    wr(8'h08, 32'h0000_1000);
    idle(3);
    rd(8'h14, v); check("R6 disabled no flag", v, 32'h0);

    // R6/R8 compare A match
    wr(8'h08, 32'h0000_1003);
    wr(8'h10, 32'h01);
    ticks(3);
    idle(3);
    rd(8'h14, v); check("R6 flag A", v, 32'h1);
    check("R8 irq A", {31'b0, irq_o}, 32'h1);
    check("R9 wake not routed", {31'b0, wake_o}, 32'h0);
    // R7 set wins while match persists
    wr(8'h14, 32'h1); idle(2);
    rd(8'h14, v); check("R7 set beats clear", v, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0); idle(2);
    rd(8'h14, v); check("R7 write 0 keeps", v, 32'h1);
    wr(8'h14, 32'h1); idle(3);
    rd(8'h14, v); check("R7 clear", v, 32'h0);
    check("R8 irq drop", {31'b0, irq_o}, 32'h0);
    eu = 32'h0000_1003;

    // R9/R10 routed wake
    wr(8'h08, eu);
    wr(8'h10, 32'h05);
    idle(3);
    rd(8'h14, v); check("R10 wake flag", v, 32'h5);
    check("R9 wake routed", {31'b0, wake_o}, 32'h1);
    wr(8'h14, 32'h7); idle(3);
    rd(8'h14, v); check("R10 no re-latch", v, 32'h1);
    wr(8'h10, 32'h80);
    wr(8'h14, 32'h7); idle(3);
    check("R9 force high", {31'b0, wake_o}, 32'h1);
    wr(8'h10, 32'h0); idle(3);
    check("R9 wake low", {31'b0, wake_o}, 32'h0);
    wr(8'h14, 32'h7); idle(2);
    rd(8'h14, v); check("R10 cleared", v, 32'h0);

    // R8 compare B, then enable removed
    wr(8'h0C, eu);
    wr(8'h10, 32'h02);
    idle(3);
    rd(8'h14, v); check("R6 flag B", v, 32'h2);
    check("R8 irq B", {31'b0, irq_o}, 32'h1);
    wr(8'h10, 32'h00); idle(3);
    check("R8 irq masked", {31'b0, irq_o}, 32'h0);
    rd(8'h14, v); check("R8 flag kept", v, 32'h2);
    wr(8'h14, 32'h2);

    // R4 clear-hold
    wr(8'h08, 32'hA5A5_0001);
    wr(8'h10, 32'h10);
    ticks(2);
    wr(8'h00, 32'h5);
    rd(8'h00, v); check("R4 up held", v, 32'h0);
    rd(8'h04, v); check("R4 down held", v, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R4 key kept", v, 32'hB5C1_3F27);
    rd(8'h08, v); check("R4 cmpA kept", v, 32'hA5A5_0001);
    rd(8'h84, v); check("R4 scratch kept", v, wv[1]);
    wr(8'h10, 32'h0);
    ticks(1);
    rd(8'h00, v); check("R3 after hold", v, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule